// File: doc/BRIEF.md
# Bucket Stripe Decision Unit

This block is the decision stage of a bucketed key/value index. One memory line holds a whole bucket, cut into `NSTRIPE` stripes. Each stripe is an item: a header (valid bit, key length, expiry second, value pointer, value length) followed by the key. Every stripe has its own evaluator, and the evaluators run side by side. Each one reports whether the stored item matches the request key, whether it has expired against the seconds counter, and whether the slot can take a new item.

A single request carries the bucket line, the operation, the key and, for an insert, the value length and expiry second. From these the unit settles a lookup, an insert or a delete. An insert needs a value block. It takes one from three size-class free queues, which present their heads first-word-fall-through. It uses a queue only when an expired item in the same line cannot lend a block of the right class. Pointers the operation frees come out on a per-stripe return port, and the updated line goes out as a write. A success reports the value pointer and length. A failure reports an error code, and the line is left as it was. A key that is not in its bucket is a miss, and no other line is ever probed.

Top module: `bucket_resolver`

## Requirements
- R1: A lookup (op code 0) that finds a live stripe with equal key length and key reports status 0 (OK) with that stripe's value pointer and length. Otherwise it reports status 1 (MISS). A lookup never writes the line, never pushes a freed pointer and never pops a free queue.
- R2: A stripe is expired when it is valid, its expiry second is non-zero and its expiry second is less than or equal to `now_sec`. An expiry of 0 never expires. A lookup treats expired stripes as absent.
- R3: An insert (op code 1) of a key that is not present writes the key, key length, expiry, pointer and value length into the lowest-index stripe that is invalid or expired. It sets that stripe's valid bit and reports OK with the pointer and length used.
- R4: The pointer class is the top 2 bits of the 32-bit pointer: 0 small, 1 medium, 2 large. The needed class is small for value lengths up to `SMALL_MAX`, medium up to `MED_MAX`, and large above that. When an insert needs a new pointer, it reuses the pointer of the lowest-index expired stripe of exactly the needed class. Only when there is none does it pop the head of that class's free queue, which is bit c of `fq_avail`/`fq_pop` and bits [32c+31:32c] of `fq_ptr`.
- R5: An insert of a key already present rewrites that stripe in place. It keeps the old pointer when the old class is at least the needed class. Otherwise it takes a new pointer as in R4 and returns the old pointer on the freed-pointer port.
- R6: A delete (op code 2) of a present key clears that stripe's valid bit, returns its pointer and reports OK with the old pointer and length. A delete of an absent key reports MISS.
- R7: A successful insert, and any delete, clear the valid bit of every expired stripe and return each such stripe's pointer, except a pointer reused by the insert. A delete writes the line when it matched or found an expired stripe.
- R8: An insert whose value length exceeds `LARGE_MAX` reports status 5 (TOOBIG). A new key with no invalid or expired stripe reports 2 (FULL). An insert that needs a pointer when no reusable one exists and the class queue is empty reports 3 (NOMEM). None of these writes, pushes or pops.
- R9: Op code 3 reports status 4 (BADOP) and writes, pushes and pops nothing.
- R10: `rsp_*`, `wr_en`, `wr_line`, `del_push` and `del_ptr` appear one clock after the request. `fq_pop` is combinational in the request cycle. After reset, `rsp_valid`, `wr_en` and `del_push` are 0.
- R11: Stripe i occupies line bits [i*W+W-1 : i*W], where W = 89 + KEY_W. Within a stripe, from the LSB up: key (KEY_W), value length (16), value pointer (32), expiry (32), key length (8), valid (1, MSB). Freed-pointer lane i is bits [32i+31:32i] of `del_ptr` and always carries stripe i's old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lookup, 1 insert, 2 delete, 3 reserved |
| req_key | input | KEY_W | Request key |
| req_klen | input | 8 | Request key length |
| req_vlen | input | 16 | Value length for insert |
| req_exp | input | 32 | Expiry second for insert (0 = never) |
| now_sec | input | 32 | Current time in seconds |
| line_in | input | NSTRIPE*(89+KEY_W) | Bucket line read from memory |
| fq_avail | input | 3 | Per-class free queue not empty |
| fq_ptr | input | 96 | Per-class free queue heads |
| fq_pop | output | 3 | Pop one class queue (request cycle) |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 3 | 0 OK, 1 MISS, 2 FULL, 3 NOMEM, 4 BADOP, 5 TOOBIG |
| rsp_vptr | output | 32 | Value pointer on success |
| rsp_vlen | output | 16 | Value length on success |
| wr_en | output | 1 | Write `wr_line` back to memory |
| wr_line | output | NSTRIPE*(89+KEY_W) | Updated bucket line |
| del_push | output | NSTRIPE | Per-stripe freed-pointer push |
| del_ptr | output | NSTRIPE*32 | Per-stripe freed pointer |

## Verification
Random requests draw keys from a pool of four, so lookups, duplicate inserts and deletes hit and miss in about equal measure. Stripes are filled at random with valid bits, live and expired expiry values and pointers of every class. Expiry is placed exactly at `now_sec`, one second past it and at 0, which separates the inclusive expiry rule from an off-by-one design and from one where 0 counts as a time. Value lengths sit on both sides of each class threshold, and queue availability is random. Together these separate keeping a pointer from reusing one from popping a queue, and show whether the reuse search takes the lowest index of the exact class. Directed cases pin down the full bucket, the empty queue, the oversize value, the reserved op code and the delete that only reclaims expired stripes.

// File: rtl/brs_pkg.sv
// Shared widths, header layout and code values for the bucket decision unit.
package brs_pkg;
    localparam int PTR_W  = 32;
    localparam int EXP_W  = 32;
    localparam int VLEN_W = 16;
    localparam int KLEN_W = 8;
    localparam int NUM_CLS = 3;
    localparam int HDR_W  = 1 + KLEN_W + EXP_W + PTR_W + VLEN_W;

    // Item header; valid is the MSB, value length the LSBs.
    typedef struct packed {
        logic              valid;
        logic [KLEN_W-1:0] klen;
        logic [EXP_W-1:0]  exp_s;
        logic [PTR_W-1:0]  vptr;
        logic [VLEN_W-1:0] vlen;
    } hdr_t;

    localparam logic [1:0] OP_GET = 2'd0;
    localparam logic [1:0] OP_INS = 2'd1;
    localparam logic [1:0] OP_DEL = 2'd2;

    localparam logic [2:0] ST_OK     = 3'd0;
    localparam logic [2:0] ST_MISS   = 3'd1;
    localparam logic [2:0] ST_FULL   = 3'd2;
    localparam logic [2:0] ST_NOMEM  = 3'd3;
    localparam logic [2:0] ST_BADOP  = 3'd4;
    localparam logic [2:0] ST_TOOBIG = 3'd5;

    // Size class carried in the top two pointer bits.
    function automatic logic [1:0] ptr_class(input logic [PTR_W-1:0] p);
        return p[PTR_W-1 -: 2];
    endfunction
endpackage

// File: rtl/brs_first_pick.sv
// Lowest-index picker: grants the lowest set request bit as a one-hot vector.
// Assumes nothing about the request pattern; an empty request gives no grant.
module brs_first_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from index 0 upward and keep the first hit.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/brs_stripe_eval.sv
// Per-stripe evaluator: raises hit, expired and vacant flags for one item.
// Assumes the header and key were sliced out of the line by the caller.
module brs_stripe_eval
    import brs_pkg::*;
#(
    parameter int KEY_W = 64
) (
    input  hdr_t                hdr,
    input  logic [KEY_W-1:0]    key,
    input  logic [KEY_W-1:0]    req_key,
    input  logic [KLEN_W-1:0]   req_klen,
    input  logic [EXP_W-1:0]    now_sec,
    output logic                hit,
    output logic                expd,
    output logic                vacant
);
    // Expiry is inclusive; a zero expiry never ages out.
    always_comb begin
        expd   = hdr.valid && (hdr.exp_s != '0) && (hdr.exp_s <= now_sec);
        vacant = !hdr.valid || expd;
        hit    = hdr.valid && !expd && (hdr.klen == req_klen) && (key == req_key);
    end
endmodule

// File: rtl/brs_ptr_source.sv
// Value pointer source for inserts: reuses the lowest expired pointer of the
// needed class, else offers the head of that class's free queue.
// Assumes the queue heads are first-word-fall-through and popped this cycle.
module brs_ptr_source
    import brs_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 want,
    input  logic [1:0]           need,
    input  logic [N-1:0]         expd,
    input  logic [N*PTR_W-1:0]   old_ptrs,
    input  logic [NUM_CLS-1:0]   fq_avail,
    input  logic [NUM_CLS*PTR_W-1:0] fq_ptr,
    output logic                 got,
    output logic [PTR_W-1:0]     ptr,
    output logic [N-1:0]         reuse_grant,
    output logic [NUM_CLS-1:0]   pop
);
    logic [N-1:0]       cand;
    logic [N-1:0]       cgrant;
    logic               cany;
    logic [PTR_W-1:0]   reuse_ptr;
    logic [PTR_W-1:0]   qhead [4];
    logic [3:0]         qok;

    // Expired stripes whose block is exactly the needed class.
    always_comb begin
        for (int i = 0; i < N; i++)
            cand[i] = expd[i] && (ptr_class(old_ptrs[i*PTR_W +: PTR_W]) == need);
    end

    brs_first_pick #(.N(N)) u_reuse_pick (
        .req   (cand),
        .grant (cgrant),
        .any   (cany)
    );

    // One-hot select of the reusable pointer.
    always_comb begin
        reuse_ptr = '0;
        for (int i = 0; i < N; i++)
            if (cgrant[i]) reuse_ptr = old_ptrs[i*PTR_W +: PTR_W];
    end

    // Queue heads padded to four entries so a 2-bit class indexes safely.
    always_comb begin
        for (int c = 0; c < NUM_CLS; c++) qhead[c] = fq_ptr[c*PTR_W +: PTR_W];
        for (int c = NUM_CLS; c < 4; c++) qhead[c] = '0;
        qok = {{(4-NUM_CLS){1'b0}}, fq_avail};
    end

    // Prefer reuse; pop the class queue only when nothing can be reused.
    always_comb begin
        got         = want && (cany || qok[need]);
        ptr         = cany ? reuse_ptr : qhead[need];
        reuse_grant = want ? cgrant : '0;
        pop         = '0;
        if (want && !cany && qok[need])
            pop = NUM_CLS'(1) << need;
    end
endmodule

// File: rtl/bucket_resolver.sv
// Bucket decision unit: evaluates all stripes of one bucket line in parallel,
// settles lookup, insert or delete, and registers the response, the line
// write-back and the freed-pointer pushes one cycle after the request.
// Assumes one bucket per line and that the caller writes wr_line when wr_en.
module bucket_resolver
    import brs_pkg::*;
#(
    parameter int NSTRIPE   = 8,
    parameter int KEY_W     = 64,
    parameter int SMALL_MAX = 64,
    parameter int MED_MAX   = 512,
    parameter int LARGE_MAX = 4096,
    localparam int STRIPE_W = HDR_W + KEY_W,
    localparam int LINE_W   = NSTRIPE * STRIPE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [KEY_W-1:0]          req_key,
    input  logic [KLEN_W-1:0]         req_klen,
    input  logic [VLEN_W-1:0]         req_vlen,
    input  logic [EXP_W-1:0]          req_exp,
    input  logic [EXP_W-1:0]          now_sec,
    input  logic [LINE_W-1:0]         line_in,
    input  logic [NUM_CLS-1:0]        fq_avail,
    input  logic [NUM_CLS*PTR_W-1:0]  fq_ptr,
    output logic [NUM_CLS-1:0]        fq_pop,
    output logic                      rsp_valid,
    output logic [2:0]                rsp_status,
    output logic [PTR_W-1:0]          rsp_vptr,
    output logic [VLEN_W-1:0]         rsp_vlen,
    output logic                      wr_en,
    output logic [LINE_W-1:0]         wr_line,
    output logic [NSTRIPE-1:0]        del_push,
    output logic [NSTRIPE*PTR_W-1:0]  del_ptr
);
    localparam logic [VLEN_W-1:0] SM_LIM = VLEN_W'(SMALL_MAX);
    localparam logic [VLEN_W-1:0] MD_LIM = VLEN_W'(MED_MAX);
    localparam logic [VLEN_W-1:0] LG_LIM = VLEN_W'(LARGE_MAX);

    hdr_t                     hdr_a [NSTRIPE];
    logic [KEY_W-1:0]         key_a [NSTRIPE];
    logic [NSTRIPE-1:0]       hit_v, expd_v, vac_v;
    logic [NSTRIPE*PTR_W-1:0] old_ptrs;
    logic [NSTRIPE-1:0]       m_grant, f_grant, tgt;
    logic                     m_any, f_any;
    hdr_t                     m_hdr;
    logic [1:0]               need, old_cls;
    logic                     too_big, keep, want_new;
    logic                     is_get, is_ins, is_del;
    logic                     got;
    logic [PTR_W-1:0]         new_ptr;
    logic [NSTRIPE-1:0]       reuse_grant;
    logic [2:0]               st_n;
    logic [PTR_W-1:0]         ptr_n;
    logic [VLEN_W-1:0]        len_n;
    logic                     ins_ok, del_ok, wr_n;
    logic [LINE_W-1:0]        line_n;
    logic [NSTRIPE-1:0]       push_n;
    logic [NSTRIPE*PTR_W-1:0] pptr_n;

    // Slice every stripe and evaluate it in parallel.
    for (genvar g = 0; g < NSTRIPE; g++) begin : g_stripe
        assign hdr_a[g] = hdr_t'(line_in[g*STRIPE_W + KEY_W +: HDR_W]);
        assign key_a[g] = line_in[g*STRIPE_W +: KEY_W];
        assign old_ptrs[g*PTR_W +: PTR_W] = hdr_a[g].vptr;

        brs_stripe_eval #(.KEY_W(KEY_W)) u_eval (
            .hdr      (hdr_a[g]),
            .key      (key_a[g]),
            .req_key  (req_key),
            .req_klen (req_klen),
            .now_sec  (now_sec),
            .hit      (hit_v[g]),
            .expd     (expd_v[g]),
            .vacant   (vac_v[g])
        );
    end

    brs_first_pick #(.N(NSTRIPE)) u_match_pick (
        .req   (hit_v),
        .grant (m_grant),
        .any   (m_any)
    );

    brs_first_pick #(.N(NSTRIPE)) u_free_pick (
        .req   (vac_v),
        .grant (f_grant),
        .any   (f_any)
    );

    // Header of the matching stripe via one-hot select.
    always_comb begin
        m_hdr = '0;
        for (int i = 0; i < NSTRIPE; i++)
            if (m_grant[i]) m_hdr = hdr_a[i];
    end

    // Size class needed by the request and whether the old block suffices.
    always_comb begin
        if (req_vlen <= SM_LIM)      need = 2'd0;
        else if (req_vlen <= MD_LIM) need = 2'd1;
        else                         need = 2'd2;
        too_big  = req_vlen > LG_LIM;
        old_cls  = ptr_class(m_hdr.vptr);
        keep     = (old_cls >= need) && (old_cls != 2'd3);
        is_get   = req_valid && (req_op == OP_GET);
        is_ins   = req_valid && (req_op == OP_INS);
        is_del   = req_valid && (req_op == OP_DEL);
        want_new = is_ins && !too_big && (m_any ? !keep : f_any);
    end

    brs_ptr_source #(.N(NSTRIPE)) u_ptr_src (
        .want        (want_new),
        .need        (need),
        .expd        (expd_v),
        .old_ptrs    (old_ptrs),
        .fq_avail    (fq_avail),
        .fq_ptr      (fq_ptr),
        .got         (got),
        .ptr         (new_ptr),
        .reuse_grant (reuse_grant),
        .pop         (fq_pop)
    );

    // Operation outcome: status, reported pointer and length.
    always_comb begin
        st_n   = ST_OK;
        ptr_n  = '0;
        len_n  = '0;
        ins_ok = 1'b0;
        del_ok = 1'b0;
        case (req_op)
            OP_GET: begin
                if (m_any) begin
                    ptr_n = m_hdr.vptr;
                    len_n = m_hdr.vlen;
                end else begin
                    st_n = ST_MISS;
                end
            end
            OP_INS: begin
                if (too_big) begin
                    st_n = ST_TOOBIG;
                end else if (m_any && keep) begin
                    ins_ok = 1'b1;
                    ptr_n  = m_hdr.vptr;
                end else if (!m_any && !f_any) begin
                    st_n = ST_FULL;
                end else if (got) begin
                    ins_ok = 1'b1;
                    ptr_n  = new_ptr;
                end else begin
                    st_n = ST_NOMEM;
                end
                if (ins_ok) len_n = req_vlen;
            end
            OP_DEL: begin
                if (m_any) begin
                    del_ok = 1'b1;
                    ptr_n  = m_hdr.vptr;
                    len_n  = m_hdr.vlen;
                end else begin
                    st_n = ST_MISS;
                end
            end
            default: st_n = ST_BADOP;
        endcase
        ins_ok = ins_ok && is_ins;
        del_ok = del_ok && is_del;
        wr_n   = ins_ok || (is_del && (m_any || (|expd_v)));
    end

    // Target stripe of an insert: the match, else the lowest vacant slot.
    assign tgt = m_any ? m_grant : f_grant;

    // Updated line and freed-pointer pushes.
    always_comb begin
        hdr_t             h;
        logic [KEY_W-1:0] k;
        logic             reclaim;
        reclaim = ins_ok || is_del;
        for (int i = 0; i < NSTRIPE; i++) begin
            h = hdr_a[i];
            k = key_a[i];
            push_n[i] = 1'b0;
            if (reclaim && expd_v[i]) begin
                h.valid   = 1'b0;
                push_n[i] = !reuse_grant[i];
            end
            if (ins_ok && tgt[i]) begin
                h.valid = 1'b1;
                h.klen  = req_klen;
                h.exp_s = req_exp;
                h.vptr  = ptr_n;
                h.vlen  = req_vlen;
                k       = req_key;
                if (m_any && !keep) push_n[i] = 1'b1;
            end
            if (del_ok && m_grant[i]) begin
                h.valid   = 1'b0;
                push_n[i] = 1'b1;
            end
            line_n[i*STRIPE_W +: STRIPE_W] = {h, k};
            pptr_n[i*PTR_W +: PTR_W] = push_n[i] ? hdr_a[i].vptr : '0;
        end
    end

    // Register the response and the memory-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_vptr   <= '0;
            rsp_vlen   <= '0;
            wr_en      <= 1'b0;
            wr_line    <= '0;
            del_push   <= '0;
            del_ptr    <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_status <= st_n;
            rsp_vptr   <= ptr_n;
            rsp_vlen   <= len_n;
            wr_en      <= wr_n;
            wr_line    <= line_n;
            del_push   <= push_n;
            del_ptr    <= pptr_n;
        end
    end
endmodule

// File: rtl/bucket_resolver_chk.sv
// Protocol checker for the bucket decision unit, bound to every instance.
// Assumes synchronous active-low reset and ports as named on the top.
module bucket_resolver_chk
    import brs_pkg::*;
#(
    parameter int N = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_op,
    input logic [NUM_CLS-1:0] fq_avail,
    input logic [NUM_CLS-1:0] fq_pop,
    input logic               rsp_valid,
    input logic [2:0]         rsp_status,
    input logic               wr_en,
    input logic [N-1:0]       del_push
);
    p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_get_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_GET) |=> (!wr_en && del_push == '0));
    p_pop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fq_pop));
    p_pop_only_ins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fq_pop != '0) |-> (req_valid && req_op == OP_INS));
    p_pop_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fq_pop & ~fq_avail) == '0);
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == ST_FULL || rsp_status == ST_NOMEM ||
                       rsp_status == ST_TOOBIG)) |-> (!wr_en && del_push == '0));
    p_badop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=>
            (rsp_status == ST_BADOP && !wr_en && del_push == '0));
endmodule

bind bucket_resolver bucket_resolver_chk #(.N(NSTRIPE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .fq_avail   (fq_avail),
    .fq_pop     (fq_pop),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .wr_en      (wr_en),
    .del_push   (del_push)
);

// File: tb/bucket_resolver_bench.sv
`timescale 1ns/1ps
module bucket_resolver_bench;
    import brs_pkg::*;
    localparam int NS = 8;
    localparam int KW = 64;
    localparam int SW = HDR_W + KW;
    localparam int LW = NS * SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            req_valid = 1'b0;
    logic [1:0]      req_op = '0;
    logic [KW-1:0]   req_key = '0;
    logic [7:0]      req_klen = '0;
    logic [15:0]     req_vlen = '0;
    logic [31:0]     req_exp = '0;
    logic [31:0]     now_sec = 32'd1000;
    logic [LW-1:0]   line_in;
    logic [2:0]      fq_avail = 3'b111;
    logic [95:0]     fq_ptr;
    logic [2:0]      fq_pop;
    logic            rsp_valid;
    logic [2:0]      rsp_status;
    logic [31:0]     rsp_vptr;
    logic [15:0]     rsp_vlen;
    logic            wr_en;
    logic [LW-1:0]   wr_line;
    logic [NS-1:0]   del_push;
    logic [NS*32-1:0] del_ptr;

    // bench-side bucket and queue state
    logic        s_valid [NS];
    logic [7:0]  s_klen [NS];
    logic [31:0] s_exp [NS];
    logic [31:0] s_ptr [NS];
    logic [15:0] s_vlen [NS];
    logic [KW-1:0] s_key [NS];
    logic [31:0] q_head [3];

    // expected results
    logic [2:0]    e_status;
    logic [31:0]   e_ptr;
    logic [15:0]   e_len;
    logic          e_wr;
    logic [LW-1:0] e_line;
    logic [NS-1:0] e_push;
    logic [2:0]    e_pop;
    string         tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Stripe layout of R11: {valid, klen, exp, ptr, vlen, key}.
    always_comb begin
        for (int i = 0; i < NS; i++)
            line_in[i*SW +: SW] = {s_valid[i], s_klen[i], s_exp[i], s_ptr[i], s_vlen[i], s_key[i]};
        fq_ptr = {q_head[2], q_head[1], q_head[0]};
    end

    bucket_resolver u_bucket_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_key(req_key), .req_klen(req_klen), .req_vlen(req_vlen),
        .req_exp(req_exp), .now_sec(now_sec), .line_in(line_in),
        .fq_avail(fq_avail), .fq_ptr(fq_ptr), .fq_pop(fq_pop),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_vptr(rsp_vptr),
        .rsp_vlen(rsp_vlen), .wr_en(wr_en), .wr_line(wr_line),
        .del_push(del_push), .del_ptr(del_ptr)
    );

    task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // Expected outcome of the current request, from the requirements.
    task automatic model();
        int mi, fi, ri, tg;
        logic [1:0] need;
        logic keep, newp, ok, anyex;
        logic [31:0] np;
        logic exf [NS];
        logic hf [NS];
        logic        e_valid [NS];
        logic [7:0]  e_klen [NS];
        logic [31:0] e_exp [NS];
        logic [31:0] e_ptrs [NS];
        logic [15:0] e_vlen [NS];
        logic [KW-1:0] e_key [NS];
        mi = -1; fi = -1; ri = -1; anyex = 1'b0;
        keep = 1'b0; newp = 1'b0; ok = 1'b0; np = '0;
        need = (req_vlen <= 16'd64) ? 2'd0 : (req_vlen <= 16'd512) ? 2'd1 : 2'd2;
        for (int i = 0; i < NS; i++) begin
            exf[i] = s_valid[i] && s_exp[i] != 32'd0 && s_exp[i] <= now_sec;
            hf[i]  = s_valid[i] && !exf[i] && s_klen[i] == req_klen && s_key[i] == req_key;
            if (hf[i] && mi < 0) mi = i;
            if ((!s_valid[i] || exf[i]) && fi < 0) fi = i;
            if (exf[i] && s_ptr[i][31:30] == need && ri < 0) ri = i;
            anyex = anyex | exf[i];
            e_valid[i] = s_valid[i]; e_klen[i] = s_klen[i]; e_exp[i] = s_exp[i];
            e_ptrs[i] = s_ptr[i]; e_vlen[i] = s_vlen[i]; e_key[i] = s_key[i];
        end
        e_status = ST_OK; e_ptr = '0; e_len = '0; e_wr = 1'b0; e_push = '0; e_pop = '0;
        case (req_op)
            OP_GET: begin
                tag = anyex ? "R2" : "R1";
                if (mi >= 0) begin e_ptr = s_ptr[mi]; e_len = s_vlen[mi]; end
                else e_status = ST_MISS;
            end
            OP_INS: begin
                tag = "R3";
                if (req_vlen > 16'd4096) begin
                    e_status = ST_TOOBIG; tag = "R8";
                end else begin
                    if (mi >= 0) begin
                        tag = "R5";
                        keep = s_ptr[mi][31:30] >= need && s_ptr[mi][31:30] != 2'd3;
                        newp = !keep; ok = keep; np = s_ptr[mi];
                    end else if (fi < 0) begin
                        e_status = ST_FULL; tag = "R8";
                    end else newp = 1'b1;
                    if (newp) begin
                        if (ri >= 0) begin np = s_ptr[ri]; ok = 1'b1; tag = "R4"; end
                        else if (fq_avail[need]) begin np = q_head[need]; e_pop = 3'b001 << need; ok = 1'b1; end
                        else begin e_status = ST_NOMEM; tag = "R8"; end
                    end
                    if (ok) begin
                        e_ptr = np; e_len = req_vlen; e_wr = 1'b1;
                        for (int i = 0; i < NS; i++)
                            if (exf[i]) begin
                                e_valid[i] = 1'b0;
                                if (!(newp && i == ri)) e_push[i] = 1'b1;
                            end
                        if (mi >= 0 && newp) e_push[mi] = 1'b1;
                        tg = (mi >= 0) ? mi : fi;
                        e_valid[tg] = 1'b1; e_klen[tg] = req_klen; e_exp[tg] = req_exp;
                        e_ptrs[tg] = np; e_vlen[tg] = req_vlen; e_key[tg] = req_key;
                    end
                end
            end
            OP_DEL: begin
                tag = anyex ? "R7" : "R6";
                for (int i = 0; i < NS; i++)
                    if (exf[i]) begin e_valid[i] = 1'b0; e_push[i] = 1'b1; end
                if (mi >= 0) begin
                    e_valid[mi] = 1'b0; e_push[mi] = 1'b1;
                    e_ptr = s_ptr[mi]; e_len = s_vlen[mi];
                end else e_status = ST_MISS;
                e_wr = (mi >= 0) || anyex;
            end
            default: begin e_status = ST_BADOP; tag = "R9"; end
        endcase
        for (int i = 0; i < NS; i++)
            e_line[i*SW +: SW] = {e_valid[i], e_klen[i], e_exp[i], e_ptrs[i], e_vlen[i], e_key[i]};
    endtask

    // Drive one request, check the pop in-cycle and the response a cycle later.
    task automatic run_req();
        model();
        @(negedge clk);
        req_valid = 1'b1;
        #1;
        chk(tag, "fq_pop", 64'(fq_pop), 64'(e_pop));
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(tag, "status", 64'(rsp_status), 64'(e_status));
        if (e_status == ST_OK) begin
            chk(tag, "vptr", 64'(rsp_vptr), 64'(e_ptr));
            chk(tag, "vlen", 64'(rsp_vlen), 64'(e_len));
        end
        chk(tag, "wr_en", 64'(wr_en), 64'(e_wr));
        if (e_wr) begin
            checks++;
            if (wr_line !== e_line) begin
                errors++;
                $display("FAIL %s line(R11): actual %h expected %h", tag, wr_line, e_line);
            end
        end
        chk(tag, "del_push", 64'(del_push), 64'(e_push));
        for (int i = 0; i < NS; i++)
            if (e_push[i]) chk(tag, "del_ptr", 64'(del_ptr[i*32 +: 32]), 64'(s_ptr[i]));
    endtask

    task automatic clear_line();
        for (int i = 0; i < NS; i++) begin
            s_valid[i] = 1'b0; s_klen[i] = '0; s_exp[i] = '0;
            s_ptr[i] = '0; s_vlen[i] = '0; s_key[i] = '0;
        end
    endtask

    task automatic put(input int i, input logic [KW-1:0] k, input logic [31:0] e,
                       input logic [31:0] p, input logic [15:0] vl);
        s_valid[i] = 1'b1; s_klen[i] = 8'd8; s_key[i] = k;
        s_exp[i] = e; s_ptr[i] = p; s_vlen[i] = vl;
    endtask

    task automatic set_req(input logic [1:0] op, input logic [KW-1:0] k, input logic [15:0] vl);
        req_op = op; req_key = k; req_klen = 8'd8; req_vlen = vl; req_exp = 32'd7000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        clear_line();
        q_head[0] = 32'h0000_1100; q_head[1] = 32'h4000_2200; q_head[2] = 32'h8000_3300;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "rsp_valid reset", 64'(rsp_valid), 64'd0);
        chk("R10", "wr_en reset", 64'(wr_en), 64'd0);
        chk("R10", "del_push reset", 64'(del_push), 64'd0);
        rst_n = 1'b1;

        // R1: lookup hit at stripe 5, and miss
        clear_line(); put(5, 64'hA1, 32'd0, 32'h4000_0055, 16'd300);
        set_req(OP_GET, 64'hA1, 16'd0); run_req();
        set_req(OP_GET, 64'hA2, 16'd0); run_req();
        // R10: idle cycle yields no response
        @(negedge clk); chk("R10", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R2: expiry equal to now is expired; zero never expires
        clear_line(); put(2, 64'hA1, 32'd1000, 32'h0000_0022, 16'd10);
        set_req(OP_GET, 64'hA1, 16'd0); run_req();
        s_exp[2] = 32'd1001; run_req();
        s_exp[2] = 32'd0; run_req();

        // R3: new key into lowest free stripe
        clear_line(); put(0, 64'hB0, 32'd0, 32'h0, 16'd1); put(1, 64'hB1, 32'd0, 32'h0, 16'd1);
        set_req(OP_INS, 64'hA1, 16'd100); run_req();

        // R4 and R7: reuse lowest expired of needed class, reclaim others
        clear_line(); put(0, 64'hB0, 32'd0, 32'h0, 16'd1);
        put(1, 64'hB1, 32'd5, 32'h8000_0011, 16'd1);
        put(3, 64'hB3, 32'd9, 32'h0000_0033, 16'd1);
        put(4, 64'hB4, 32'd9, 32'h0000_0044, 16'd1);
        set_req(OP_INS, 64'hA1, 16'd32); run_req();

        // R5: existing key keeps pointer, then grows into a new class
        clear_line(); put(3, 64'hA1, 32'd0, 32'h4000_0abc, 16'd200);
        set_req(OP_INS, 64'hA1, 16'd100); run_req();
        set_req(OP_INS, 64'hA1, 16'd600); run_req();

        // R6: delete hit, delete miss with nothing expired
        clear_line(); put(6, 64'hA1, 32'd0, 32'h0000_0066, 16'd5);
        set_req(OP_DEL, 64'hA1, 16'd0); run_req();
        set_req(OP_DEL, 64'hA3, 16'd0); run_req();
        // R7: delete miss that only reclaims
        put(2, 64'hB2, 32'd3, 32'h4000_0022, 16'd5);
        run_req();

        // R8: full bucket, empty queue, oversize value
        clear_line();
        for (int i = 0; i < NS; i++) put(i, 64'hC0 + 64'(i), 32'd0, 32'h0, 16'd1);
        set_req(OP_INS, 64'hA1, 16'd10); run_req();
        s_valid[4] = 1'b0; fq_avail = 3'b110; run_req();
        fq_avail = 3'b111;
        set_req(OP_INS, 64'hA1, 16'd5000); run_req();

        // R9: reserved op code
        set_req(2'd3, 64'hC1, 16'd10); run_req();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NS; i++) begin
                int ec;
                s_valid[i] = ($urandom % 3) != 0;
                s_klen[i]  = ($urandom % 5 == 0) ? 8'd4 : 8'd8;
                s_key[i]   = 64'hA0 + 64'($urandom % 4);
                ec = int'($urandom % 5);
                s_exp[i]   = (ec == 0) ? 32'd0 : (ec == 1) ? 32'd500 : (ec == 2) ? 32'd1000 :
                             (ec == 3) ? 32'd1001 : 32'd5000;
                s_ptr[i]   = {2'($urandom % 3), 30'($urandom)};
                s_vlen[i]  = 16'($urandom % 4000);
            end
            for (int c = 0; c < 3; c++) q_head[c] = {2'(c), 30'($urandom)};
            fq_avail = 3'($urandom);
            begin
                int oc, vc;
                oc = int'($urandom % 8);
                vc = int'($urandom % 7);
                req_op   = (oc < 2) ? OP_GET : (oc < 5) ? OP_INS : (oc < 7) ? OP_DEL : 2'd3;
                req_key  = 64'hA0 + 64'($urandom % 4);
                req_klen = ($urandom % 5 == 0) ? 8'd4 : 8'd8;
                req_vlen = (vc == 0) ? 16'd1 : (vc == 1) ? 16'd64 : (vc == 2) ? 16'd65 :
                           (vc == 3) ? 16'd512 : (vc == 4) ? 16'd513 : (vc == 5) ? 16'd4096 : 16'd4097;
                req_exp  = $urandom;
            end
            run_req();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule